// File: doc/BRIEF.md
# Prioritized Transmit Buffer Manager

This block owns the state of a small set of outgoing message buffers. Each buffer has a 4-bit state, and all states are packed into one status word. Software moves buffers between states with a command strobe. The strobe carries a select mask with one bit per buffer and three operation bits: mark ready, mark empty and abort. A per-buffer priority comes in through a packed priority word.

While the controller is enabled and no frame is in flight, the block picks the ready buffer with the highest non-zero priority. It hands that buffer's index to the frame transmitter with a level request and waits for a done pulse, which carries an error flag. When the transmitter answers, the block records the outcome in the buffer's state, counts good frames and pulses the completion events. Frame serialization and bus arbitration are left to the transmitter.

Top module: `txbuf_mgr`

## Requirements
- R1: After reset every buffer is empty (state code 0), the status word reads 0, the frame counter is 0, `tx_req` is low and `idle` is high. State codes are: empty=0, ready=1, sent-ok=2, error=3, aborted=4. Buffer i's state sits in bits [4i+3:4i] of `status_word`.
- R2: Mark-ready moves a buffer from empty, sent-ok, error or aborted to ready. Mark-empty moves a buffer from sent-ok, error or aborted to empty, and leaves a ready buffer unchanged. Abort moves a ready buffer to aborted and leaves any other state alone.
- R3: When several operation bits arrive in one strobe, they apply to each selected buffer in a fixed order: abort first, then mark-ready, then mark-empty. A command touches only the buffers whose bit in `cmd_sel` is set.
- R4: A command strobe has no effect while `ctrl_en` is low.
- R5: Buffer i's priority is bits [4i+2:4i] of `prio_word`. The buffer chosen is the ready buffer with the highest priority. Among ready buffers that share that priority, the lowest index wins. A transmission starts on the clock edge after the winning buffer becomes ready, and only while `ctrl_en` is high and no transmission is active.
- R6: A ready buffer with priority 0 is never handed to the transmitter.
- R7: While a transmission is active, `tx_req` stays high and `tx_idx` holds still. A command aimed at the active buffer leaves that buffer unchanged.
- R8: On `tx_done` with `tx_err` low, the active buffer becomes sent-ok, `frame_cnt` increments and `evt_tx_done` pulses for one cycle. On `tx_done` with `tx_err` high, the buffer becomes error and the counter holds. In both cases `evt_buf_chg` pulses for one cycle.
- R9: `transmitting` is high and `idle` is low exactly while a transmission is active.
- R10: `not_full` is high whenever at least one buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_sel | input | NUM_BUF | Buffer select mask |
| cmd_ready | input | 1 | Mark-ready operation |
| cmd_empty | input | 1 | Mark-empty operation |
| cmd_abort | input | 1 | Abort operation |
| prio_word | input | 4*NUM_BUF | Packed priorities, one nibble per buffer |
| status_word | output | 4*NUM_BUF | Packed buffer states |
| not_full | output | 1 | At least one buffer empty |
| idle | output | 1 | No transmission active |
| transmitting | output | 1 | Transmission active |
| tx_req | output | 1 | Request to the transmitter |
| tx_idx | output | IDX_W | Index of the buffer being sent |
| tx_done | input | 1 | Transmitter finished, one cycle |
| tx_err | input | 1 | Outcome flag with `tx_done` |
| frame_cnt | output | CNT_W | Count of frames sent without error |
| evt_tx_done | output | 1 | Pulse on a good completion |
| evt_buf_chg | output | 1 | Pulse when a completion changes a buffer state |

## Verification
A corrupted state nibble appears on `status_word` on the clock edge after the command or completion that caused it. It also shows up one cycle later as a wrong choice, or a missing choice, of `tx_idx` at the next request. A wrong arbitration result shows at the rising edge of `tx_req`, where the scoreboard compares the index against its queue of expected buffers. Lost or doubled completions show in `frame_cnt` and in the event pulses sampled in the cycle after `tx_done`.

// File: rtl/txq_pkg.sv
package txq_pkg;
   localparam int unsigned ST_W = 4;
   typedef enum logic [ST_W-1:0] {
      BS_EMPTY = 4'd0,
      BS_READY = 4'd1,
      BS_OK    = 4'd2,
      BS_ERR   = 4'd3,
      BS_ABORT = 4'd4
   } buf_state_e;

   // Abort is applied first, then mark-ready, then mark-empty.
   function automatic buf_state_e cmd_next(input buf_state_e cur, input logic abort_op,
                                           input logic ready_op, input logic empty_op);
      buf_state_e s;
      s = cur;
      if (abort_op && s == BS_READY) s = BS_ABORT;
      if (ready_op && (s == BS_EMPTY || s == BS_OK || s == BS_ERR || s == BS_ABORT)) s = BS_READY;
      if (empty_op && (s == BS_OK || s == BS_ERR || s == BS_ABORT)) s = BS_EMPTY;
      return s;
   endfunction
endpackage

// File: rtl/txq_arbiter.sv
module txq_arbiter #(
   parameter int unsigned NUM_BUF = 4,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic [NUM_BUF-1:0]        ready_vec,
   input  logic [NUM_BUF*4-1:0]      prio_word,
   input  logic [NUM_BUF-1:0]        lock_vec,
   output logic                      win_valid,
   output logic [IDX_W-1:0]          win_idx
);
   logic [PRIO_W-1:0] prio [NUM_BUF];

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_prio
      assign prio[g] = prio_word[g*4 +: PRIO_W];
   end

   always_comb begin
      logic [PRIO_W-1:0] best;
      best      = '0;
      win_valid = 1'b0;
      win_idx   = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         // strict compare: equal priority keeps the lower index; zero never wins
         if (ready_vec[i] && !lock_vec[i] && prio[i] > best) begin
            best      = prio[i];
            win_valid = 1'b1;
            win_idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
   parameter int unsigned NUM_BUF = 4,
   parameter int unsigned CNT_W   = 16,
   localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_en,
   input  logic             win_valid,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             tx_done,
   input  logic             tx_err,
   output logic             busy,
   output logic [IDX_W-1:0] act_idx,
   output logic             start,
   output logic             finish,
   output logic [CNT_W-1:0] frame_cnt,
   output logic             evt_tx_done,
   output logic             evt_buf_chg
);
   assign start  = !busy && ctrl_en && win_valid;
   assign finish = busy && tx_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         act_idx     <= '0;
         frame_cnt   <= '0;
         evt_tx_done <= 1'b0;
         evt_buf_chg <= 1'b0;
      end else begin
         evt_tx_done <= finish && !tx_err;
         evt_buf_chg <= finish;
         if (start) begin
            busy    <= 1'b1;
            act_idx <= win_idx;
         end else if (finish) begin
            busy <= 1'b0;
         end
         if (finish && !tx_err) frame_cnt <= frame_cnt + 1'b1;
      end
   end

   a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_done) |=> (busy && $stable(act_idx)));
   a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_done && !tx_err) |=> (frame_cnt == $past(frame_cnt) + 1'b1));
   a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_done && tx_err) |=> $stable(frame_cnt));
endmodule

// File: rtl/txbuf_mgr.sv
module txbuf_mgr
   import txq_pkg::*;
#(
   parameter int unsigned NUM_BUF = 4,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned CNT_W   = 16,
   localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_en,
   input  logic                 cmd_valid,
   input  logic [NUM_BUF-1:0]   cmd_sel,
   input  logic                 cmd_ready,
   input  logic                 cmd_empty,
   input  logic                 cmd_abort,
   input  logic [NUM_BUF*4-1:0] prio_word,
   output logic [NUM_BUF*4-1:0] status_word,
   output logic                 not_full,
   output logic                 idle,
   output logic                 transmitting,
   output logic                 tx_req,
   output logic [IDX_W-1:0]     tx_idx,
   input  logic                 tx_done,
   input  logic                 tx_err,
   output logic [CNT_W-1:0]     frame_cnt,
   output logic                 evt_tx_done,
   output logic                 evt_buf_chg
);
   initial begin
      assert (NUM_BUF >= 1 && NUM_BUF <= 8) else $error("NUM_BUF out of range");
      assert (PRIO_W >= 1 && PRIO_W <= 4) else $error("PRIO_W must fit a nibble");
      assert (CNT_W >= 1) else $error("CNT_W must be positive");
   end

   buf_state_e             st [NUM_BUF];
   logic [NUM_BUF-1:0]     ready_vec, empty_vec, lock_vec;
   logic                   win_valid, busy, start, finish;
   logic [IDX_W-1:0]       win_idx, act_idx;

   txq_arbiter #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W)) u_arb (
      .ready_vec (ready_vec),
      .prio_word (prio_word),
      .lock_vec  ('0),
      .win_valid (win_valid),
      .win_idx   (win_idx)
   );

   txq_ctrl #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_en     (ctrl_en),
      .win_valid   (win_valid),
      .win_idx     (win_idx),
      .tx_done     (tx_done),
      .tx_err      (tx_err),
      .busy        (busy),
      .act_idx     (act_idx),
      .start       (start),
      .finish      (finish),
      .frame_cnt   (frame_cnt),
      .evt_tx_done (evt_tx_done),
      .evt_buf_chg (evt_buf_chg)
   );

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
      logic cmd_hit;
      // the buffer in flight, or the one being launched this cycle, is locked
      assign lock_vec[g]  = busy ? (act_idx == IDX_W'(g)) : (start && win_idx == IDX_W'(g));
      assign cmd_hit      = cmd_valid && ctrl_en && cmd_sel[g] && !lock_vec[g];
      assign ready_vec[g] = (st[g] == BS_READY);
      assign empty_vec[g] = (st[g] == BS_EMPTY);
      assign status_word[g*4 +: 4] = st[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st[g] <= BS_EMPTY;
         end else if (finish && act_idx == IDX_W'(g)) begin
            st[g] <= tx_err ? BS_ERR : BS_OK;
         end else if (cmd_hit) begin
            st[g] <= cmd_next(st[g], cmd_abort, cmd_ready, cmd_empty);
         end
      end

      a_r7_lock_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && act_idx == IDX_W'(g) && !tx_done) |=> (st[g] == $past(st[g])));
   end

   assign not_full     = |empty_vec;
   assign tx_req       = busy;
   assign tx_idx       = act_idx;
   assign transmitting = busy;
   assign idle         = !busy;

   a_r5_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_req) |-> (status_word[tx_idx*4 +: 4] == 4'(BS_READY)));
   a_r6_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_req) |-> (prio_word[tx_idx*4 +: PRIO_W] != '0));
   a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !tx_req) |=> $stable(status_word));
   a_r9_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (idle != transmitting));
endmodule

// File: tb/txbuf_mgr_tb.sv
module txbuf_mgr_tb;
   localparam int NB = 4;
   logic clk = 0, rst_n = 0, ctrl_en = 0, cmd_valid = 0, cmd_ready = 0, cmd_empty = 0, cmd_abort = 0;
   logic [NB-1:0] cmd_sel = '0;
   logic [NB*4-1:0] prio_word = '0, status_word;
   logic not_full, idle, transmitting, tx_req, tx_done = 0, tx_err = 0, evt_tx_done, evt_buf_chg;
   logic [1:0] tx_idx;
   logic [15:0] frame_cnt;
   int n_chk = 0, n_bad = 0;
   int exp_cnt = 0;
   typedef struct { int idx; bit err; } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   txbuf_mgr u_dut (.*);

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmd(logic [NB-1:0] sel, bit a, bit r, bit e);
      @(negedge clk);
      cmd_valid = 1; cmd_sel = sel; cmd_abort = a; cmd_ready = r; cmd_empty = e;
      @(negedge clk);
      cmd_valid = 0; cmd_sel = '0; cmd_abort = 0; cmd_ready = 0; cmd_empty = 0;
   endtask

   task automatic expect_tx(int idx, bit err);
      item_t it;
      it.idx = idx; it.err = err;
      sb.push_back(it);
   endtask

   // monitor + transmitter model
   initial begin
      logic prev = 0;
      forever begin
         @(negedge clk);
         if (rst_n && tx_req && !prev) begin
            item_t it;
            if (sb.size() == 0) begin
               check("R6 unexpected request", 1, 0);
            end else begin
               it = sb.pop_front();
               check("R5 tx_idx", tx_idx, it.idx);
               check("R9 transmitting", {transmitting, idle}, 2'b10);
               repeat (3) @(negedge clk);
               check("R7 req held", {tx_req, tx_idx}, {1'b1, 2'(it.idx)});
               tx_done = 1; tx_err = it.err;
               @(negedge clk);
               tx_done = 0; tx_err = 0;
               if (!it.err) exp_cnt++;
               check("R8 evt_tx_done", evt_tx_done, !it.err);
               check("R8 evt_buf_chg", evt_buf_chg, 1);
               check("R8 frame_cnt", frame_cnt, exp_cnt);
            end
         end
         prev = tx_req;
      end
   end

   initial begin
      #1_600_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic drain();
      repeat (4) @(negedge clk);
      while (sb.size() != 0 || tx_req) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", status_word, 0);
      check("R1 idle/req", {idle, tx_req}, 2'b10);
      check("R1 frame_cnt", frame_cnt, 0);
      check("R10 not_full", not_full, 1);

      // R4 disabled: command ignored
      prio_word = 16'h0552;        // b0=2 b1=5 b2=5 b3=0
      cmd(4'hF, 0, 1, 0);
      @(negedge clk);
      check("R4 ignored when disabled", status_word, 0);

      // R5/R6 ordering, tie to low index, zero prio skipped
      ctrl_en = 1;
      expect_tx(1, 0); expect_tx(2, 1); expect_tx(0, 0);
      cmd(4'hF, 0, 1, 0);
      drain();
      check("R8 final states", status_word, 16'h1322);
      check("R6 prio0 still ready", status_word[15:12], 1);
      check("R10 none empty", not_full, 0);
      check("R9 idle after", {idle, transmitting}, 2'b10);
      check("R8 count", frame_cnt, 2);

      // R2 mark-empty: ok/err -> empty, ready unchanged
      cmd(4'hF, 0, 0, 1);
      @(negedge clk);
      check("R2 empty cmd", status_word, 16'h1000);
      check("R10 not_full", not_full, 1);
      // R2 abort: ready->aborted, empty untouched
      cmd(4'h9, 1, 0, 0);
      check("R2 abort", status_word, 16'h4000);
      // R3 select mask: only buf3 marked ready
      cmd(4'h8, 0, 1, 0);
      check("R3 sel mask", status_word, 16'h1000);
      // R3 combined: abort, ready, empty -> ready
      cmd(4'h8, 1, 1, 1);
      check("R3 combo a+r+e", status_word, 16'h1000);
      // R3 combined: abort then empty -> empty
      cmd(4'h8, 1, 0, 1);
      check("R3 combo a+e", status_word, 16'h0000);

      // R7 lock of active buffer
      prio_word = 16'h0001;
      expect_tx(0, 0);
      cmd(4'h1, 0, 1, 0);
      @(negedge clk);
      cmd(4'h1, 1, 0, 0);
      check("R7 active not aborted", status_word[3:0], 1);
      drain();
      check("R7 after done", status_word[3:0], 2);
      check("R8 count 3", frame_cnt, 3);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule